// File: doc/BRIEF.md
# Bus Error Status Register

This block holds the 16-bit status word of a PCI host bridge configuration header. The bus engine reports each error event as a one-cycle pulse. The block records each event in a sticky flag, and the flag stays set until software writes a one to its bit position. The parity-error-response enable from the command register is an input. The word also returns fixed capability bits that describe the bridge.

Software writes the word through a plain write port. The port has two byte enables: enable 1 covers bits 15..8 and enable 0 covers bits 7..0. The read value is always present on `rd_data`. A recorded event appears there in the cycle after the clock edge that samples the pulse. There is no streamed data path, so every pin is a plain control or status signal with no handshake. Reset is synchronous and active-high.

Top module: `bus_err_status`

## Requirements
- R1: While `rst` is high, and after it is released, every sticky flag is 0. The read value is then 0x0080 with bit 5 set to the `CAP_66MHZ` parameter, which gives 0x00A0 by default.
- R2: Bit 15 sets after any cycle with `ev_par_det` high. This happens whatever the values of `perr_resp_en` and `ev_is_master`.
- R3: Bit 14 sets after any cycle with `ev_serr_drive` high.
- R4: Bit 13 sets after a cycle with `ev_mabort_end` high and `ev_special` low. When `ev_special` is high, that pulse leaves the bit unchanged.
- R5: Bit 12 sets after a cycle with `ev_tabort_rcvd` high and `ev_special` low. When `ev_special` is high, that pulse leaves the bit unchanged.
- R6: Bit 11 sets after any cycle with `ev_tabort_sent` high.
- R7: Bit 8 sets only after a cycle in which `ev_par_det`, `ev_is_master` and `perr_resp_en` are all high.
- R8: A write with `wr_be[1]` high clears each of bits 15..11 and bit 8 whose `wr_data` bit is 1. A data bit of 0 leaves the flag unchanged. With `wr_be[1]` low the write clears nothing.
- R9: If a flag's set event and a clearing write fall in the same cycle, the flag ends up set.
- R10: Bits 10, 9, 6, 4 and 3..0 always read 0, and bit 7 always reads 1. Writes never change any of these bits, nor bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_par_det | input | 1 | Pulse: bus parity error detected |
| ev_serr_drive | input | 1 | Pulse: bridge drove the system-error line |
| ev_mabort_end | input | 1 | Pulse: bridge as master ended a transfer with master-abort |
| ev_tabort_rcvd | input | 1 | Pulse: transfer started by the bridge was target-aborted |
| ev_tabort_sent | input | 1 | Pulse: bridge as target issued a target-abort |
| ev_is_master | input | 1 | Qualifier: bridge is the bus master for the current operation |
| ev_special | input | 1 | Qualifier: current transfer is a special cycle |
| perr_resp_en | input | 1 | Parity-error-response enable from the command register |
| wr_en | input | 1 | Write strobe for the status word |
| wr_be | input | 2 | Byte enables; index 1 covers bits 15..8 |
| wr_data | input | 16 | Write data; a 1 clears the matching sticky flag |
| rd_data | output | 16 | Current status word |

## Verification
The hardest case to reach is the collision: a set event and a one-write to the same flag landing in the same cycle. The stimulus drives a master parity error with responses enabled and a clearing write of bits 15 and 8 together. It then confirms that both flags survive. The special-cycle exclusions and the three-way condition on bit 8 also need deliberate stimulus. Each of these is driven with one qualifier missing at a time, so that a flag which sets too easily is caught.

// File: rtl/bstat_pkg.sv
package bstat_pkg;
  localparam int SW = 16;
  localparam int LANES = SW / 8;

  // bit positions decoded by software
  localparam int B_DPE  = 15;
  localparam int B_SSE  = 14;
  localparam int B_RMA  = 13;
  localparam int B_RTA  = 12;
  localparam int B_STA  = 11;
  localparam int B_MDPE = 8;
  localparam int B_FBB  = 7;
  localparam int B_66   = 5;

  localparam logic [SW-1:0] W1C_MASK =
    (SW'(1) << B_DPE) | (SW'(1) << B_SSE) | (SW'(1) << B_RMA) |
    (SW'(1) << B_RTA) | (SW'(1) << B_STA) | (SW'(1) << B_MDPE);

  typedef struct packed {
    logic par_det;
    logic serr;
    logic mabort;
    logic tabort_rx;
    logic tabort_tx;
    logic master;
    logic special;
  } bus_evt_t;
endpackage

// File: rtl/err_event_decode.sv
module err_event_decode
  import bstat_pkg::*;
(
  input  bus_evt_t        evt,
  input  logic            perr_en,
  output logic [SW-1:0]   set_vec
);
  always_comb begin
    set_vec         = '0;
    set_vec[B_DPE]  = evt.par_det;
    set_vec[B_SSE]  = evt.serr;
    set_vec[B_RMA]  = evt.mabort & ~evt.special;
    set_vec[B_RTA]  = evt.tabort_rx & ~evt.special;
    set_vec[B_STA]  = evt.tabort_tx;
    set_vec[B_MDPE] = evt.par_det & evt.master & perr_en;
  end
endmodule

// File: rtl/w1c_strobe_gen.sv
module w1c_strobe_gen #(
  parameter int W = 16,
  localparam int NL = W / 8
) (
  input  logic          wr_en,
  input  logic [NL-1:0] wr_be,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  clr_vec
);
  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign clr_vec[l*8 +: 8] = (wr_en && wr_be[l]) ? wr_data[l*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/w1c_flag.sv
module w1c_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  // R8
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);
  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/bus_err_status.sv
module bus_err_status
  import bstat_pkg::*;
#(
  parameter bit CAP_66MHZ = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ev_par_det,
  input  logic        ev_serr_drive,
  input  logic        ev_mabort_end,
  input  logic        ev_tabort_rcvd,
  input  logic        ev_tabort_sent,
  input  logic        ev_is_master,
  input  logic        ev_special,
  input  logic        perr_resp_en,
  input  logic        wr_en,
  input  logic [1:0]  wr_be,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data
);
  localparam logic [SW-1:0] FIXED_ONES =
    (SW'(1) << B_FBB) | (SW'(CAP_66MHZ) << B_66);

  bus_evt_t      evt;
  logic [SW-1:0] set_vec;
  logic [SW-1:0] clr_vec;
  logic [SW-1:0] sticky;
  logic          unused_bits;

  assign evt = '{par_det:   ev_par_det,
                 serr:      ev_serr_drive,
                 mabort:    ev_mabort_end,
                 tabort_rx: ev_tabort_rcvd,
                 tabort_tx: ev_tabort_sent,
                 master:    ev_is_master,
                 special:   ev_special};

  err_event_decode u_dec (
    .evt     (evt),
    .perr_en (perr_resp_en),
    .set_vec (set_vec)
  );

  w1c_strobe_gen #(.W(SW)) u_clr (
    .wr_en   (wr_en),
    .wr_be   (wr_be),
    .wr_data (wr_data),
    .clr_vec (clr_vec)
  );

  for (genvar i = 0; i < SW; i++) begin : g_bit
    if (W1C_MASK[i]) begin : g_flag
      w1c_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_vec[i]),
        .clr_i (clr_vec[i]),
        .q_o   (sticky[i])
      );
    end else begin : g_const
      assign sticky[i] = 1'b0;
    end
  end

  assign unused_bits = ^((set_vec | clr_vec) & ~W1C_MASK);
  assign rd_data = sticky | FIXED_ONES;

  // R2
  dpe_any_chk: assert property (@(posedge clk) disable iff (rst)
    ev_par_det |=> rd_data[B_DPE]);
  // R7
  mdpe_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_par_det && ev_is_master && perr_resp_en) |=> rd_data[B_MDPE]);
  // R7
  mdpe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!(ev_par_det && ev_is_master && perr_resp_en) && !rd_data[B_MDPE])
      |=> !rd_data[B_MDPE]);
  // R4
  rma_special_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_mabort_end && ev_special && !rd_data[B_RMA]) |=> !rd_data[B_RMA]);
  // R5
  rta_special_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_tabort_rcvd && ev_special && !rd_data[B_RTA]) |=> !rd_data[B_RTA]);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> ((rd_data & W1C_MASK) == '0));
endmodule

// File: tb/test_bus_err_status.sv
module test_bus_err_status;
  logic clk = 1'b0;
  logic rst;
  logic ev_par_det, ev_serr_drive, ev_mabort_end, ev_tabort_rcvd;
  logic ev_tabort_sent, ev_is_master, ev_special, perr_resp_en;
  logic wr_en;
  logic [1:0] wr_be;
  logic [15:0] wr_data;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [15:0] exp; string req; } item_t;
  item_t sb[$];
  logic [15:0] model = '0;

  localparam logic [15:0] FIXED = 16'h00A0;
  localparam logic [15:0] WMASK = 16'hF900;

  always #2 clk = ~clk;

  bus_err_status i_bus_err_status (
    .clk, .rst, .ev_par_det, .ev_serr_drive, .ev_mabort_end,
    .ev_tabort_rcvd, .ev_tabort_sent, .ev_is_master, .ev_special,
    .perr_resp_en, .wr_en, .wr_be, .wr_data, .rd_data
  );

  // ev bits: {par, serr, mabort, tabort_rx, tabort_tx, master, special, perr_en}
  task automatic step(input logic r, input logic [7:0] ev,
                      input logic we, input logic [1:0] be,
                      input logic [15:0] d, input string req);
    logic [15:0] setv, clrv;
    item_t it;
    rst = r;
    {ev_par_det, ev_serr_drive, ev_mabort_end, ev_tabort_rcvd,
     ev_tabort_sent, ev_is_master, ev_special, perr_resp_en} = ev;
    wr_en = we; wr_be = be; wr_data = d;
    setv = '0;
    setv[15] = ev[7];
    setv[14] = ev[6];
    setv[13] = ev[5] & ~ev[1];
    setv[12] = ev[4] & ~ev[1];
    setv[11] = ev[3];
    setv[8]  = ev[7] & ev[2] & ev[0];
    clrv = (we && be[1]) ? (d & WMASK) : 16'h0;
    @(posedge clk);
    if (r) model = '0;
    else   model = (model & ~clrv) | setv;
    it.exp = model | FIXED;
    it.req = req;
    sb.push_back(it);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (sb.size() != 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rd_data !== it.exp) begin
        errors++;
        $display("FAIL %s: rd_data=%h expected=%h", it.req, rd_data, it.exp);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ev_par_det = 0; ev_serr_drive = 0; ev_mabort_end = 0;
    ev_tabort_rcvd = 0; ev_tabort_sent = 0; ev_is_master = 0; ev_special = 0;
    perr_resp_en = 0; wr_en = 0; wr_be = 0; wr_data = 0;
    @(negedge clk);
    step(1, 8'h00, 0, 2'b00, 16'h0, "R1 reset");
    step(1, 8'hF8, 1, 2'b11, 16'hFFFF, "R1 reset with events");
    step(0, 8'h00, 0, 2'b00, 16'h0, "R1 idle after reset");
    // R2: parity without enable or master role, bit 8 stays clear (R7)
    step(0, 8'h80, 0, 2'b00, 16'h0, "R2 parity detect");
    // R8: low lane enable cannot clear
    step(0, 8'h00, 1, 2'b01, 16'h8000, "R8 low lane no clear");
    step(0, 8'h00, 1, 2'b10, 16'h8000, "R8 high lane clear");
    step(0, 8'h40, 0, 2'b00, 16'h0, "R3 system error");
    step(0, 8'h00, 1, 2'b11, 16'h0000, "R8 zero write keeps");
    step(0, 8'h22, 0, 2'b00, 16'h0, "R4 special master-abort ignored");
    step(0, 8'h20, 0, 2'b00, 16'h0, "R4 master-abort");
    step(0, 8'h12, 0, 2'b00, 16'h0, "R5 special target-abort ignored");
    step(0, 8'h10, 0, 2'b00, 16'h0, "R5 target-abort received");
    step(0, 8'h08, 0, 2'b00, 16'h0, "R6 target-abort sent");
    step(0, 8'h00, 1, 2'b10, 16'hFF00, "R8 clear all flags");
    step(0, 8'h84, 0, 2'b00, 16'h0, "R7 master parity, response off");
    step(0, 8'h81, 0, 2'b00, 16'h0, "R7 parity enabled, not master");
    step(0, 8'h85, 0, 2'b00, 16'h0, "R7 master data parity");
    step(0, 8'h00, 1, 2'b10, 16'h0100, "R8 clear bit 8 only");
    step(0, 8'h00, 1, 2'b11, 16'hFFFF, "R10 read-only bits ignore writes");
    step(0, 8'h85, 1, 2'b11, 16'h8100, "R9 set beats clear");
    step(0, 8'hC8, 1, 2'b11, 16'h0000, "R3 R6 several events");
    step(1, 8'h00, 0, 2'b00, 16'h0, "R1 reset clears flags");
    step(0, 8'h00, 0, 2'b00, 16'h0, "R10 fixed bits after reset");
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule